// File: doc/BRIEF.md
# Fetcher Pointer Update Sequencer

This block is a multi-cycle engine that serves fetcher reads for a virtual instruction emitter. It holds two 16-bit group base pointers, each pointing at a table of 16-bit data pointers. A fetch request selects a group and a fetcher index. The engine reads the data pointer from the table, returns the byte that pointer addresses, and then writes the pointer back. The write-back applies either a plain increment or a counted-run step. In the counted-run step, a second pointer stored next to the first leads to a countdown byte, and the parity of that second pointer decides whether the data pointer advances.

The same engine also runs loop processing on the two base pointers. Loop counters and reload words sit in memory just below each base pointer. A loop-test request either counts down the loop counters or reloads the bases. A jump-loop request does the same and also produces a new virtual program counter. All traffic goes over one byte-wide memory port, one access per cycle. The read data for an access is returned in the same cycle as the access. Words are little-endian: the low byte is at the lower address and is accessed first.

Top module: `fetch_ptr_seq`

## Requirements
- R1: After reset, `req_ready` is high, `mem_rd`, `mem_wr`, `rsp_done` and `rsp_pc_valid` are low, and the group 0 and group 1 bases equal the parameters `BASE0_RST` and `BASE1_RST`.
- R2: A fetch computes the entry address as base[`req_group`] + 2 × `req_index`. It reads the entry's low byte at the entry address and its high byte at the entry address + 1. It then reads the byte at the resulting data pointer, and that byte appears on `rsp_data` when `rsp_done` is raised.
- R3: When `req_inc` is not all-ones, the data pointer plus `req_inc` is written back: the low byte to the entry address, then the high byte to the entry address + 1.
- R4: When `req_inc` is all-ones, the fetch takes the counted-run step:
  - The engine reads a second pointer from the entry address + 2 and + 3, then reads the count byte that second pointer addresses.
  - A non-zero count is written back to the same address, decremented by one.
  - A zero count causes no write, and the second pointer is taken as one higher.
  - The written-back data pointer is one higher than the one read if and only if the (possibly incremented) second pointer is odd.
  - The second pointer itself is never written.
- R5: The engine makes at most one memory access per cycle and never reads and writes in the same cycle. `req_ready` is low from the cycle after acceptance up to the last access. `rsp_done` is a one-cycle pulse in the cycle after the last access.
- R6: Loop-test first reads the count byte at base0 − 4. If that byte is zero:
  - base0 is reloaded from the word at (old) base0 − 2.
  - base1 is then loaded from the word at new base0 − 8.
  - The program counter is then loaded from the word at new base0 − 6, and `rsp_pc_valid` pulses with `rsp_done`.
- R7: If the base0 count is non-zero, it is written back decremented. The byte at base1 − 4 is then read. If it is zero, base1 is reloaded from the word at base1 − 2. Otherwise it is written back decremented. A loop-test that takes this path leaves `rsp_pc_valid` low.
- R8: A jump-loop behaves as a loop-test. On the non-zero base0 path it also loads the program counter from the word at base1 − 6, using base1 after its update, and pulses `rsp_pc_valid`.
- R9: `req_kind` is encoded as follows: 2'b01 is loop-test, 2'b10 is jump-loop, and 2'b00 and 2'b11 are both fetch.
- R10: A request presented while `req_ready` is low has no effect on the memory traffic or the responses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Engine idle, request taken this cycle |
| req_group | input | 1 | Base pointer select |
| req_index | input | IDX_W | Fetcher index in the group table |
| req_inc | input | INC_W | Increment code; all-ones selects counted run |
| req_kind | input | 2 | Request kind (see R9) |
| mem_addr | output | 16 | Memory byte address |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write data |
| mem_rdata | input | 8 | Memory read data, same cycle as `mem_rd` |
| rsp_done | output | 1 | Request finished (one cycle) |
| rsp_data | output | 8 | Fetched data byte |
| rsp_pc | output | 16 | Virtual program counter |
| rsp_pc_valid | output | 1 | `rsp_pc` updated by this request |

## Verification
The hardest situation to reach is the zero-count reload of base0. It needs a loop counter that has already been counted down by earlier loop requests, and its result is only visible through the addresses that later requests use. The stimulus places small counts below both bases and issues a fixed chain of loop-test and jump-loop requests. This chain walks base1 through its decrement and reload paths, and finally drives base0 through its reload. Fetches issued afterwards then show the new bases in their entry addresses. Counted-run fetches are aimed at second pointers of both parities, with zero and non-zero counts, so that all four outcomes of the parity rule occur.

// File: rtl/fps_pkg.sv
package fps_pkg;

   localparam int PTR_W = 16;
   localparam int BYTE_W = 8;

   typedef enum logic [1:0] {
      KIND_FETCH_A = 2'b00,
      KIND_LTEST   = 2'b01,
      KIND_JLOOP   = 2'b10,
      KIND_FETCH_B = 2'b11
   } fps_kind_e;

   typedef enum logic [4:0] {
      ST_IDLE, ST_PL, ST_PH, ST_DAT, ST_CL, ST_CH, ST_CRD, ST_CWR,
      ST_WL, ST_WH, ST_LC0, ST_LW0, ST_LN0L, ST_LN0H, ST_LB1L,
      ST_LB1H, ST_LPL, ST_LPH, ST_LC1, ST_LW1, ST_LN1L, ST_LN1H
   } fps_state_e;

endpackage

// File: rtl/fps_base_regs.sv
module fps_base_regs
   import fps_pkg::*;
#(
   parameter logic [15:0] BASE0_RST = 16'h0400,
   parameter logic [15:0] BASE1_RST = 16'h0800
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [1:0]                 ld_i,
   input  logic [PTR_W-1:0]           val_i,
   output logic [1:0][PTR_W-1:0]      base_o
);

   for (genvar g = 0; g < 2; g++) begin : g_base
      localparam logic [PTR_W-1:0] RST_V = (g == 0) ? BASE0_RST : BASE1_RST;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            base_o[g] <= RST_V;
         else if (ld_i[g])
            base_o[g] <= val_i;
      end
   end

endmodule

// File: rtl/fps_run_step.sv
module fps_run_step
   import fps_pkg::*;
#(
   parameter int INC_W = 3
) (
   input  logic [PTR_W-1:0]  ptr_i,
   input  logic [INC_W-1:0]  inc_i,
   input  logic              cptr_lsb_i,
   input  logic [BYTE_W-1:0] cnt_i,
   output logic              inc_max_o,
   output logic              cnt_zero_o,
   output logic [PTR_W-1:0]  plain_o,
   output logic [PTR_W-1:0]  run_o
);

   localparam logic [INC_W-1:0] INC_MAX = '1;

   logic odd_after;

   always_comb begin
      inc_max_o  = (inc_i == INC_MAX);
      cnt_zero_o = (cnt_i == '0);
      plain_o    = ptr_i + PTR_W'(inc_i);
      // a zero count bumps the second pointer, flipping its parity
      odd_after  = cnt_zero_o ? ~cptr_lsb_i : cptr_lsb_i;
      run_o      = ptr_i + PTR_W'(odd_after);
   end

endmodule

// File: rtl/fps_addr_mux.sv
module fps_addr_mux
   import fps_pkg::*;
(
   input  fps_state_e         state_i,
   input  logic [PTR_W-1:0]   entry_i,
   input  logic [PTR_W-1:0]   ptr_i,
   input  logic [PTR_W-1:0]   cptr_i,
   input  logic [PTR_W-1:0]   base0_i,
   input  logic [PTR_W-1:0]   base1_i,
   input  logic               via_b1_i,
   input  logic [BYTE_W-1:0]  cnt_i,
   output logic [PTR_W-1:0]   addr_o,
   output logic               rd_o,
   output logic               wr_o,
   output logic [BYTE_W-1:0]  wdata_o
);

   logic [PTR_W-1:0] pc_base;

   always_comb begin
      pc_base = via_b1_i ? base1_i : base0_i;
      addr_o  = '0;
      rd_o    = 1'b0;
      wr_o    = 1'b0;
      wdata_o = '0;
      unique case (state_i)
         ST_PL:   begin addr_o = entry_i;               rd_o = 1'b1; end
         ST_PH:   begin addr_o = entry_i + 16'd1;       rd_o = 1'b1; end
         ST_DAT:  begin addr_o = ptr_i;                 rd_o = 1'b1; end
         ST_CL:   begin addr_o = entry_i + 16'd2;       rd_o = 1'b1; end
         ST_CH:   begin addr_o = entry_i + 16'd3;       rd_o = 1'b1; end
         ST_CRD:  begin addr_o = cptr_i;                rd_o = 1'b1; end
         ST_CWR:  begin addr_o = cptr_i;                wr_o = 1'b1; wdata_o = cnt_i - 8'd1; end
         ST_WL:   begin addr_o = entry_i;               wr_o = 1'b1; wdata_o = ptr_i[7:0]; end
         ST_WH:   begin addr_o = entry_i + 16'd1;       wr_o = 1'b1; wdata_o = ptr_i[15:8]; end
         ST_LC0:  begin addr_o = base0_i - 16'd4;       rd_o = 1'b1; end
         ST_LW0:  begin addr_o = base0_i - 16'd4;       wr_o = 1'b1; wdata_o = cnt_i - 8'd1; end
         ST_LN0L: begin addr_o = base0_i - 16'd2;       rd_o = 1'b1; end
         ST_LN0H: begin addr_o = base0_i - 16'd1;       rd_o = 1'b1; end
         ST_LB1L: begin addr_o = base0_i - 16'd8;       rd_o = 1'b1; end
         ST_LB1H: begin addr_o = base0_i - 16'd7;       rd_o = 1'b1; end
         ST_LPL:  begin addr_o = pc_base - 16'd6;       rd_o = 1'b1; end
         ST_LPH:  begin addr_o = pc_base - 16'd5;       rd_o = 1'b1; end
         ST_LC1:  begin addr_o = base1_i - 16'd4;       rd_o = 1'b1; end
         ST_LW1:  begin addr_o = base1_i - 16'd4;       wr_o = 1'b1; wdata_o = cnt_i - 8'd1; end
         ST_LN1L: begin addr_o = base1_i - 16'd2;       rd_o = 1'b1; end
         ST_LN1H: begin addr_o = base1_i - 16'd1;       rd_o = 1'b1; end
         default: ;
      endcase
   end

endmodule

// File: rtl/fetch_ptr_seq.sv
module fetch_ptr_seq
   import fps_pkg::*;
#(
   parameter int          IDX_W     = 5,
   parameter int          INC_W     = 3,
   parameter logic [15:0] BASE0_RST = 16'h0400,
   parameter logic [15:0] BASE1_RST = 16'h0800
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic              req_group,
   input  logic [IDX_W-1:0]  req_index,
   input  logic [INC_W-1:0]  req_inc,
   input  logic [1:0]        req_kind,
   output logic [15:0]       mem_addr,
   output logic              mem_rd,
   output logic              mem_wr,
   output logic [7:0]        mem_wdata,
   input  logic [7:0]        mem_rdata,
   output logic              rsp_done,
   output logic [7:0]        rsp_data,
   output logic [15:0]       rsp_pc,
   output logic              rsp_pc_valid
);

   if (IDX_W < 1 || IDX_W > PTR_W - 2) begin : g_bad_idx
      $error("fetch_ptr_seq: IDX_W out of range");
   end
   if (INC_W < 1 || INC_W > 7) begin : g_bad_inc
      $error("fetch_ptr_seq: INC_W out of range");
   end

   fps_state_e              state_q;
   logic [PTR_W-1:0]        entry_q, ptr_q, cptr_q, pc_q;
   logic [BYTE_W-1:0]       cnt_q, tmp_q, data_q;
   logic [INC_W-1:0]        inc_q;
   logic                    jump_q, via_b1_q, done_q, pcv_q;
   logic [1:0]              base_ld;
   logic [1:0][PTR_W-1:0]   base;
   logic [PTR_W-1:0]        rd_word, plain_ptr, run_ptr;
   logic                    inc_max, cnt_zero;

   assign rd_word = {mem_rdata, tmp_q};

   fps_base_regs #(.BASE0_RST(BASE0_RST), .BASE1_RST(BASE1_RST)) u_base (
      .clk(clk), .rst_n(rst_n), .ld_i(base_ld), .val_i(rd_word), .base_o(base)
   );

   fps_run_step #(.INC_W(INC_W)) u_step (
      .ptr_i(ptr_q), .inc_i(inc_q), .cptr_lsb_i(cptr_q[0]), .cnt_i(mem_rdata),
      .inc_max_o(inc_max), .cnt_zero_o(cnt_zero), .plain_o(plain_ptr), .run_o(run_ptr)
   );

   fps_addr_mux u_mux (
      .state_i(state_q), .entry_i(entry_q), .ptr_i(ptr_q), .cptr_i(cptr_q),
      .base0_i(base[0]), .base1_i(base[1]), .via_b1_i(via_b1_q), .cnt_i(cnt_q),
      .addr_o(mem_addr), .rd_o(mem_rd), .wr_o(mem_wr), .wdata_o(mem_wdata)
   );

   always_comb begin
      base_ld = 2'b00;
      if (state_q == ST_LN0H) base_ld[0] = 1'b1;
      if (state_q == ST_LB1H || state_q == ST_LN1H) base_ld[1] = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         entry_q  <= '0;
         ptr_q    <= '0;
         cptr_q   <= '0;
         pc_q     <= '0;
         cnt_q    <= '0;
         tmp_q    <= '0;
         data_q   <= '0;
         inc_q    <= '0;
         jump_q   <= 1'b0;
         via_b1_q <= 1'b0;
         done_q   <= 1'b0;
         pcv_q    <= 1'b0;
      end else begin
         done_q <= 1'b0;
         pcv_q  <= 1'b0;
         unique case (state_q)
            ST_IDLE: if (req_valid) begin
               entry_q  <= base[req_group] + PTR_W'({req_index, 1'b0});
               inc_q    <= req_inc;
               via_b1_q <= 1'b0;
               jump_q   <= (req_kind == KIND_JLOOP);
               if (req_kind == KIND_LTEST || req_kind == KIND_JLOOP)
                  state_q <= ST_LC0;
               else
                  state_q <= ST_PL;
            end
            ST_PL:   begin ptr_q[7:0]  <= mem_rdata; state_q <= ST_PH; end
            ST_PH:   begin ptr_q[15:8] <= mem_rdata; state_q <= ST_DAT; end
            ST_DAT:  begin
               data_q <= mem_rdata;
               if (inc_max) state_q <= ST_CL;
               else begin ptr_q <= plain_ptr; state_q <= ST_WL; end
            end
            ST_CL:   begin cptr_q[7:0]  <= mem_rdata; state_q <= ST_CH; end
            ST_CH:   begin cptr_q[15:8] <= mem_rdata; state_q <= ST_CRD; end
            ST_CRD:  begin
               ptr_q <= run_ptr;
               cnt_q <= mem_rdata;
               state_q <= cnt_zero ? ST_WL : ST_CWR;
            end
            ST_CWR:  state_q <= ST_WL;
            ST_WL:   state_q <= ST_WH;
            ST_WH:   begin state_q <= ST_IDLE; done_q <= 1'b1; end
            ST_LC0:  begin
               cnt_q <= mem_rdata;
               state_q <= cnt_zero ? ST_LN0L : ST_LW0;
            end
            ST_LW0:  begin via_b1_q <= 1'b1; state_q <= ST_LC1; end
            ST_LN0L: begin tmp_q <= mem_rdata; state_q <= ST_LN0H; end
            ST_LN0H: state_q <= ST_LB1L;
            ST_LB1L: begin tmp_q <= mem_rdata; state_q <= ST_LB1H; end
            ST_LB1H: state_q <= ST_LPL;
            ST_LPL:  begin tmp_q <= mem_rdata; state_q <= ST_LPH; end
            ST_LPH:  begin
               pc_q <= rd_word; pcv_q <= 1'b1; done_q <= 1'b1; state_q <= ST_IDLE;
            end
            ST_LC1:  begin
               cnt_q <= mem_rdata;
               state_q <= cnt_zero ? ST_LN1L : ST_LW1;
            end
            ST_LW1, ST_LN1H: begin
               if (jump_q) state_q <= ST_LPL;
               else begin state_q <= ST_IDLE; done_q <= 1'b1; end
            end
            ST_LN1L: begin tmp_q <= mem_rdata; state_q <= ST_LN1H; end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign req_ready    = (state_q == ST_IDLE);
   assign rsp_done     = done_q;
   assign rsp_data     = data_q;
   assign rsp_pc       = pc_q;
   assign rsp_pc_valid = pcv_q;

   p_one_access_r5: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_rd && mem_wr));

   p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_done |=> !rsp_done);

   p_deref_le_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_DAT) |-> (mem_rd && mem_addr == {$past(mem_rdata), $past(mem_rdata, 2)}));

   p_wb_high_next_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_WH) |-> (mem_wr && mem_addr == $past(mem_addr) + 16'd1));

   p_pc_with_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_pc_valid |-> rsp_done);

   p_base_hold_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_IDLE) |=> $stable(base));

endmodule

// File: tb/fetch_ptr_seq_tb_top.sv
module fetch_ptr_seq_tb_top;

   localparam int          IDX_W = 5;
   localparam int          INC_W = 3;
   localparam logic [15:0] B0    = 16'h0400;
   localparam logic [15:0] B1    = 16'h0800;

   typedef struct {
      bit          rd;
      bit          wr;
      logic [15:0] addr;
      logic [7:0]  wd;
      bit          done;
      bit          chk_data;
      logic [7:0]  data;
      bit          pcv;
      logic [15:0] pc;
      string       tag;
   } item_t;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0, req_group = 1'b0;
   logic [IDX_W-1:0] req_index = '0;
   logic [INC_W-1:0] req_inc = '0;
   logic [1:0] req_kind = 2'b00;
   logic req_ready, mem_rd, mem_wr, rsp_done, rsp_pc_valid;
   logic [15:0] mem_addr, rsp_pc;
   logic [7:0] mem_wdata, mem_rdata, rsp_data;

   logic [7:0] mem [0:4095];
   logic [7:0] rm  [0:4095];
   item_t q[$];
   logic [15:0] mb0, mb1, mpc;
   int checks = 0, fails = 0, cyc = 0;
   string note = "reset", idle_tag = "R1";

   always #5 clk = ~clk;

   assign mem_rdata = mem[mem_addr[11:0]];
   always @(posedge clk) if (mem_wr) mem[mem_addr[11:0]] <= mem_wdata;

   fetch_ptr_seq #(.IDX_W(IDX_W), .INC_W(INC_W), .BASE0_RST(B0), .BASE1_RST(B1)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
      .req_group(req_group), .req_index(req_index), .req_inc(req_inc), .req_kind(req_kind),
      .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr), .mem_wdata(mem_wdata),
      .mem_rdata(mem_rdata), .rsp_done(rsp_done), .rsp_data(rsp_data),
      .rsp_pc(rsp_pc), .rsp_pc_valid(rsp_pc_valid)
   );

   function automatic logic [15:0] rw(input logic [15:0] a);
      logic [15:0] a1 = a + 16'd1;
      return {rm[a1[11:0]], rm[a[11:0]]};
   endfunction

   task automatic set_b(input logic [15:0] a, input logic [7:0] v);
      mem[a[11:0]] = v;
      rm[a[11:0]]  = v;
   endtask

   task automatic set_w(input logic [15:0] a, input logic [15:0] v);
      set_b(a, v[7:0]);
      set_b(a + 16'd1, v[15:8]);
   endtask

   task automatic push_rd(input logic [15:0] a, input string t);
      item_t it = '{rd: 1, wr: 0, addr: a, wd: 0, done: 0, chk_data: 0, data: 0, pcv: 0, pc: 0, tag: t};
      q.push_back(it);
   endtask

   task automatic push_wr(input logic [15:0] a, input logic [7:0] v, input string t);
      item_t it = '{rd: 0, wr: 1, addr: a, wd: v, done: 0, chk_data: 0, data: 0, pcv: 0, pc: 0, tag: t};
      rm[a[11:0]] = v;
      q.push_back(it);
   endtask

   task automatic push_done(input bit cd, input logic [7:0] d, input bit pv, input string t);
      item_t it = '{rd: 0, wr: 0, addr: 0, wd: 0, done: 1, chk_data: cd, data: d, pcv: pv, pc: mpc, tag: t};
      q.push_back(it);
   endtask

   // reference for a fetch (R2, R3, R4)
   task automatic model_fetch(input bit g, input int idx, input int inc);
      logic [15:0] e, p, c;
      logic [7:0] d, v;
      e = (g ? mb1 : mb0) + 16'(idx * 2);
      push_rd(e, "R2");
      push_rd(e + 16'd1, "R2");
      p = rw(e);
      push_rd(p, "R2");
      d = rm[p[11:0]];
      if (inc != 7) p = p + 16'(inc);
      else begin
         push_rd(e + 16'd2, "R4");
         push_rd(e + 16'd3, "R4");
         c = rw(e + 16'd2);
         push_rd(c, "R4");
         v = rm[c[11:0]];
         if (v == 8'd0) c = c + 16'd1;
         else push_wr(c, v - 8'd1, "R4");
         if (c[0]) p = p + 16'd1;
      end
      push_wr(e, p[7:0], "R3");
      push_wr(e + 16'd1, p[15:8], "R3");
      push_done(1, d, 0, "R2");
   endtask

   // reference for loop-test / jump-loop (R6, R7, R8)
   task automatic model_loop(input bit jump);
      logic [7:0] v;
      push_rd(mb0 - 16'd4, "R6");
      v = rm[(mb0 - 16'd4) & 16'h0fff];
      if (v == 8'd0) begin
         push_rd(mb0 - 16'd2, "R6");
         push_rd(mb0 - 16'd1, "R6");
         mb0 = rw(mb0 - 16'd2);
         push_rd(mb0 - 16'd8, "R6");
         push_rd(mb0 - 16'd7, "R6");
         mb1 = rw(mb0 - 16'd8);
         push_rd(mb0 - 16'd6, "R6");
         push_rd(mb0 - 16'd5, "R6");
         mpc = rw(mb0 - 16'd6);
         push_done(0, 0, 1, "R6");
      end else begin
         push_wr(mb0 - 16'd4, v - 8'd1, "R7");
         push_rd(mb1 - 16'd4, "R7");
         v = rm[(mb1 - 16'd4) & 16'h0fff];
         if (v == 8'd0) begin
            push_rd(mb1 - 16'd2, "R7");
            push_rd(mb1 - 16'd1, "R7");
            mb1 = rw(mb1 - 16'd2);
         end else push_wr(mb1 - 16'd4, v - 8'd1, "R7");
         if (jump) begin
            push_rd(mb1 - 16'd6, "R8");
            push_rd(mb1 - 16'd5, "R8");
            mpc = rw(mb1 - 16'd6);
            push_done(0, 0, 1, "R8");
         end else push_done(0, 0, 0, "R7");
      end
   endtask

   task automatic summary_and_end();
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   endtask

   task automatic step();
      item_t it;
      bit ok, exp_ready;
      @(negedge clk);
      cyc++;
      if (cyc > 20000) begin
         fails++;
         $display("FAIL R5 watchdog: actual cycles=%0d expected below 20000", cyc);
         summary_and_end();
      end
      if (q.size() > 0) it = q.pop_front();
      else it = '{rd: 0, wr: 0, addr: 0, wd: 0, done: 0, chk_data: 0, data: 0, pcv: 0, pc: 0, tag: idle_tag};
      exp_ready = (it.rd || it.wr) ? 1'b0 : 1'b1;
      ok = (mem_rd === it.rd) && (mem_wr === it.wr) && (rsp_done === it.done) &&
           (req_ready === exp_ready) && (rsp_pc_valid === it.pcv);
      if (it.rd || it.wr) ok = ok && (mem_addr === it.addr);
      if (it.wr) ok = ok && (mem_wdata === it.wd);
      if (it.chk_data) ok = ok && (rsp_data === it.data);
      if (it.pcv) ok = ok && (rsp_pc === it.pc);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s (%s) cyc %0d: actual rd=%0b wr=%0b addr=%h wd=%h done=%0b data=%h pcv=%0b pc=%h rdy=%0b; expected rd=%0b wr=%0b addr=%h wd=%h done=%0b data=%h pcv=%0b pc=%h rdy=%0b",
                  it.tag, note, cyc, mem_rd, mem_wr, mem_addr, mem_wdata, rsp_done, rsp_data,
                  rsp_pc_valid, rsp_pc, req_ready, it.rd, it.wr, it.addr, it.wd, it.done,
                  it.data, it.pcv, it.pc, exp_ready);
      end
   endtask

   // kind: 0/3 fetch, 1 loop-test, 2 jump-loop (R9); hold keeps a junk request up while busy (R10)
   task automatic issue(input logic [1:0] kind, input bit g, input int idx, input int inc,
                        input string n, input bit hold);
      note = n;
      if (kind == 2'b01) model_loop(0);
      else if (kind == 2'b10) model_loop(1);
      else model_fetch(g, idx, inc);
      req_valid = 1'b1;
      req_kind  = kind;
      req_group = g;
      req_index = IDX_W'(idx);
      req_inc   = INC_W'(inc);
      while (q.size() > 0) begin
         step();
         if (!hold || (q.size() > 0 && q[0].done) || q.size() == 0) req_valid = 1'b0;
         else begin
            req_kind  = ~kind;
            req_group = ~g;
            req_index = ~req_index;
            req_inc   = req_inc + 1'b1;
         end
      end
      step();
   endtask

   initial begin
      for (int i = 0; i < 4096; i++) begin
         mem[i] = 8'(i * 29 + 7);
         rm[i]  = 8'(i * 29 + 7);
      end
      mb0 = B0; mb1 = B1; mpc = 16'h0000;
      // fetch tables
      set_w(16'h0400, 16'h0500);
      set_w(16'h0806, 16'h0520);
      set_w(16'h040A, 16'h0540); set_w(16'h040C, 16'h0600); set_b(16'h0600, 8'd3);
      set_w(16'h040E, 16'h0550); set_w(16'h0410, 16'h0611); set_b(16'h0611, 8'd1);
      set_w(16'h0802, 16'h0560); set_w(16'h0804, 16'h0620); set_b(16'h0620, 8'd0);
      set_w(16'h080A, 16'h0570); set_w(16'h080C, 16'h0631); set_b(16'h0631, 8'd0);
      // loop bookkeeping below the bases
      set_b(16'h03FC, 8'd2); set_w(16'h03FE, 16'h0C00);
      set_w(16'h0BF8, 16'h0E00); set_w(16'h0BFA, 16'h1234);
      set_b(16'h07FC, 8'd1); set_w(16'h07FE, 16'h0900); set_w(16'h07FA, 16'h2345);
      set_b(16'h08FC, 8'd5); set_w(16'h08FA, 16'h3456);

      // R1: reset state held over a few cycles and just after release
      repeat (3) step();
      rst_n = 1'b1;
      repeat (2) step();
      idle_tag = "R5";

      issue(2'b00, 0, 0, 1, "R2 R3 g0 idx0 inc1, R1 base0 reset value", 0);
      issue(2'b00, 1, 3, 2, "R2 R3 g1 idx3 inc2, R1 base1 reset value", 0);
      issue(2'b00, 0, 0, 0, "R3 zero increment", 0);
      issue(2'b00, 0, 5, 7, "R4 count 3 even second pointer", 0);
      issue(2'b00, 0, 5, 7, "R4 count 2 even second pointer", 0);
      issue(2'b00, 0, 7, 7, "R4 count 1 odd second pointer", 0);
      issue(2'b00, 1, 1, 7, "R4 count 0 even becomes odd", 0);
      issue(2'b00, 1, 5, 7, "R4 count 0 odd becomes even", 0);
      issue(2'b00, 0, 7, 7, "R4 count now 0 odd becomes even", 0);
      issue(2'b11, 0, 2, 3, "R9 kind 3 fetches", 0);
      issue(2'b00, 1, 4, 5, "R10 request held high while busy", 1);
      issue(2'b01, 0, 0, 0, "R7 loop-test both counts non-zero", 0);
      issue(2'b10, 0, 0, 0, "R8 jump-loop base1 reload", 0);
      issue(2'b01, 0, 0, 0, "R6 loop-test base0 reload", 1);
      issue(2'b00, 0, 1, 4, "R6 fetch via reloaded base0", 0);
      issue(2'b00, 1, 0, 1, "R6 fetch via reloaded base1", 0);
      issue(2'b10, 0, 0, 0, "R8 R9 jump-loop after reload", 0);
      issue(2'b01, 0, 0, 0, "R7 R9 loop-test after reload", 0);
      repeat (3) step();
      summary_and_end();
   end

endmodule